// File: doc/BRIEF.md
# Transmit Descriptor Ring Prefetcher

This block walks a circular ring of transmit buffer descriptors held in memory on behalf of a transmit engine. For each descriptor it reads the descriptor word and then the data words that the descriptor points to, pushing the data into a transmit FIFO. A frame may use several descriptors. Descriptors that do not end a frame are written back with their ready flag cleared as soon as their data has been moved. The descriptor that ends a frame stays in flight until the transmit side reports that the frame is done, and is then written back. Because the engine runs ahead of transmission, it normally holds the next frame's descriptor while the current frame is still being sent.

The block keeps a small table of the frame-ending descriptors that are still in flight. After the ring wraps, the next index can point at a descriptor that has been fetched but not yet written back. Memory still shows that descriptor as ready, so fetching it again would send its frame twice. The block stalls the prefetch while the next index matches any table entry, and also while the table is full. When a fetched descriptor is not ready, the block parks. It leaves the park on a software kick or when a frame-done event needs a write-back.

Control is a single state machine with these states:
- ST_PARK: idle. Entered after reset and after a not-ready descriptor.
- ST_CHECK: decides what to do next.
- ST_DESC: reads the descriptor.
- ST_DATA: moves the data words.
- ST_WBACK: writes back a descriptor that does not end a frame.
- ST_RETIRE: writes back the oldest in-flight descriptor.

The transitions are:
- ST_PARK goes to ST_RETIRE when a retire is pending, and to ST_CHECK on a kick.
- ST_CHECK goes to ST_RETIRE when a retire is pending. Otherwise it goes to ST_DESC when the next index is neither in flight nor blocked by a full table.
- ST_DESC goes to ST_DATA when the descriptor is ready, and to ST_PARK when it is not.
- ST_DATA goes to ST_CHECK when its data ends a frame, and to ST_WBACK otherwise.
- ST_WBACK and ST_RETIRE both go to ST_CHECK once their write is acknowledged.

Top module: `txr_prefetch`

## Requirements
- R1: After synchronous reset the ring index is 0 and the in-flight table is empty. The block stays in ST_PARK and makes no memory request and no FIFO write until sw_kick.
- R2: A descriptor is one 32-bit word read at address cfg_base + index. Its fields are: bit 31 ready, bit 30 end of frame, bits 29:24 length in data words, bits 23:0 data word address. A descriptor is read once per pass while it is not yet written back.
- R3: The data words at ptr, ptr+1, and so on up to ptr+len-1 are read in order. Each one is written to the FIFO (fifo_wr with fifo_data) in the cycle its memory acknowledge arrives. A new data read starts only while fifo_full is low.
- R4: A descriptor whose end-of-frame bit is clear is written back right after its last data word: bit 31 is cleared and all other bits are unchanged. A descriptor whose end-of-frame bit is set keeps bit 31 set in memory until its frame-done.
- R5: Each tx_done pulse retires the oldest in-flight frame by writing its end descriptor back with bit 31 cleared and the other bits unchanged. A tx_done pulse while no frame is in flight is ignored: no memory write and no read follow.
- R6: After index cfg_size-1 the index wraps to 0.
- R7: No descriptor is read while its index is held in the in-flight table, or while the table holds INF_DEPTH entries. A frame whose end descriptor is in flight is therefore never fetched again before its write-back.
- R8: A descriptor read with bit 31 clear moves the block to ST_PARK. It then makes no memory access until sw_kick or a tx_done, and a kick resumes at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | AW | Word address of ring entry 0 |
| cfg_size | input | IDX_W+1 | Number of ring entries |
| sw_kick | input | 1 | Software pulse: new descriptors are available |
| tx_done | input | 1 | Pulse from the transmit side: oldest frame sent |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write data |
| fifo_full | input | 1 | FIFO cannot take another word |

## Verification
A FIFO word is due in the same cycle as the memory acknowledge that returns it. The bench compares each word on the falling edge of any cycle where fifo_wr is high, against a stream it built from the descriptors it wrote. A write-back or a re-read takes several handshake cycles, each of two clocks, after the event that causes it, whether the last data word or a tx_done. Memory images and access counts are therefore checked only after a fixed settling window of 30 to 60 cycles. Frame-done pulses are issued at least three cycles after a frame's last word, so that the frame is already in the in-flight table when the pulse arrives.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int RDY_BIT  = 31;
    localparam int LAST_BIT = 30;
    localparam int LEN_LSB  = 24;
    localparam int LEN_W    = 6;
    localparam logic [31:0] RDY_MASK = 32'h8000_0000;

    typedef enum logic [2:0] {
        ST_PARK,
        ST_CHECK,
        ST_DESC,
        ST_DATA,
        ST_WBACK,
        ST_RETIRE
    } txr_state_e;
endpackage

// File: rtl/txr_ring_idx.sv
module txr_ring_idx #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W:0]   size,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] nxt;

    assign nxt = {1'b0, idx} + (IDX_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            if (nxt >= size) idx <= '0;
            else             idx <= nxt[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/txr_inflight.sv
module txr_inflight #(
    parameter int IDX_W = 4,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [31:0]      push_word,
    input  logic             pop,
    input  logic [IDX_W-1:0] probe,
    output logic             hit,
    output logic             full,
    output logic [CW-1:0]    count,
    output logic [IDX_W-1:0] head_idx,
    output logic [31:0]      head_word
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] e_idx  [DEPTH];
    logic [31:0]      e_word [DEPTH];
    logic [DEPTH-1:0] e_vld;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    head, tail;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = e_vld[g] && (e_idx[g] == probe);
    end

    assign hit       = |match;
    assign full      = (count == CW'(DEPTH));
    assign head_idx  = e_idx[head];
    assign head_word = e_word[head];

    always_ff @(posedge clk) begin
        if (rst) begin
            e_vld <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                e_idx[tail]  <= push_idx;
                e_word[tail] <= push_word;
                e_vld[tail]  <= 1'b1;
                tail         <= step(tail);
            end
            if (pop) begin
                e_vld[head] <= 1'b0;
                head        <= step(head);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/txr_prefetch.sv
module txr_prefetch
    import txr_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int INF_DEPTH = 4,
    parameter int AW        = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_base,
    input  logic [IDX_W:0]   cfg_size,
    input  logic             sw_kick,
    input  logic             tx_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             fifo_wr,
    output logic [31:0]      fifo_data,
    input  logic             fifo_full
);
    localparam int CW = $clog2(INF_DEPTH + 1);

    txr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, head_idx;
    logic [31:0]      desc_q, head_word;
    logic [LEN_W-1:0] cnt_q;
    logic [CW-1:0]    done_cnt, occ;
    logic             tbl_hit, tbl_full, tbl_push, tbl_pop, idx_adv;
    logic             data_end, done_inc, retire_due, desc_last;

    assign desc_last  = desc_q[LAST_BIT];
    assign data_end   = (cnt_q == desc_q[LEN_LSB +: LEN_W]);
    assign retire_due = (done_cnt != '0);
    assign done_inc   = tx_done && (done_cnt < occ);
    assign fifo_data  = mem_rdata;

    txr_ring_idx #(.IDX_W(IDX_W)) ring_i (
        .clk  (clk),
        .rst  (rst),
        .adv  (idx_adv),
        .size (cfg_size),
        .idx  (idx_q)
    );

    txr_inflight #(.IDX_W(IDX_W), .DEPTH(INF_DEPTH), .CW(CW)) tbl_i (
        .clk       (clk),
        .rst       (rst),
        .push      (tbl_push),
        .push_idx  (idx_q),
        .push_word (desc_q),
        .pop       (tbl_pop),
        .probe     (idx_q),
        .hit       (tbl_hit),
        .full      (tbl_full),
        .count     (occ),
        .head_idx  (head_idx),
        .head_word (head_word)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PARK;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK: begin
                if (retire_due)   state_d = ST_RETIRE;
                else if (sw_kick) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (retire_due)                 state_d = ST_RETIRE;
                else if (!tbl_hit && !tbl_full) state_d = ST_DESC;
            end
            ST_DESC: begin
                if (mem_ack) state_d = mem_rdata[RDY_BIT] ? ST_DATA : ST_PARK;
            end
            ST_DATA: begin
                if (data_end) state_d = desc_last ? ST_CHECK : ST_WBACK;
            end
            ST_WBACK:  if (mem_ack) state_d = ST_CHECK;
            ST_RETIRE: if (mem_ack) state_d = ST_CHECK;
            default:   state_d = ST_PARK;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fifo_wr   = 1'b0;
        tbl_push  = 1'b0;
        tbl_pop   = 1'b0;
        idx_adv   = 1'b0;
        unique case (state_q)
            ST_DESC: begin
                mem_req  = 1'b1;
                mem_addr = cfg_base + AW'(idx_q);
            end
            ST_DATA: begin
                mem_req  = !data_end && !fifo_full;
                mem_addr = desc_q[AW-1:0] + AW'(cnt_q);
                fifo_wr  = mem_ack;
                tbl_push = data_end && desc_last;
                idx_adv  = data_end && desc_last;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cfg_base + AW'(idx_q);
                mem_wdata = desc_q & ~RDY_MASK;
                idx_adv   = mem_ack;
            end
            ST_RETIRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cfg_base + AW'(head_idx);
                mem_wdata = head_word & ~RDY_MASK;
                tbl_pop   = mem_ack;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q   <= '0;
            cnt_q    <= '0;
            done_cnt <= '0;
        end else begin
            if (state_q == ST_DESC && mem_ack) begin
                desc_q <= mem_rdata;
                cnt_q  <= '0;
            end else if (state_q == ST_DATA && mem_ack) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            done_cnt <= done_cnt + CW'(done_inc) - CW'(tbl_pop);
        end
    end
endmodule

// File: rtl/txr_prefetch_chk.sv
module txr_prefetch_chk
    import txr_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int INF_DEPTH = 4,
    parameter int CW        = 3
) (
    input logic             clk,
    input logic             rst,
    input txr_state_e       state_q,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic             fifo_wr,
    input logic             tbl_hit,
    input logic [CW-1:0]    occ,
    input logic [IDX_W-1:0] idx_q,
    input logic [IDX_W:0]   cfg_size
);
    // R3
    fifo_wr_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> mem_ack);

    // R7
    no_inflight_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DESC && mem_req) |-> !tbl_hit);

    // R7
    table_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(INF_DEPTH));

    // R6
    idx_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_size != '0) |-> ({1'b0, idx_q} < cfg_size));

    // R4
    wb_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // R8
    park_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARK) |-> !mem_req);
endmodule

bind txr_prefetch txr_prefetch_chk #(
    .IDX_W(IDX_W), .INF_DEPTH(INF_DEPTH), .CW(CW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .fifo_wr   (fifo_wr),
    .tbl_hit   (tbl_hit),
    .occ       (occ),
    .idx_q     (idx_q),
    .cfg_size  (cfg_size)
);

// File: tb/txr_prefetch_tb_top.sv
`timescale 1ns/1ps
module txr_prefetch_tb_top;
    localparam int IDX_W = 4;
    localparam int AW    = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_base = '0;
    logic [IDX_W:0] cfg_size = 5'd2;
    logic          sw_kick = 1'b0;
    logic          tx_done = 1'b0;
    logic          mem_req, mem_we, mem_ack, fifo_wr;
    logic          fifo_full = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata, fifo_data;

    always #2.5 clk = ~clk;

    txr_prefetch #(.IDX_W(IDX_W), .INF_DEPTH(4), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .sw_kick(sw_kick), .tx_done(tx_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dv(input int a);
        return 32'hD000_0000 ^ (a * 32'h0001_0003);
    endfunction

    function automatic logic [31:0] mk(input int len, input bit last, input int ptr);
        return {1'b1, last, 6'(len), 24'(ptr)};
    endfunction

    // memory model with bench write port
    logic [31:0] mem [0:255];
    int          rd_cnt [0:255];
    int          wr_total = 0;
    logic        tb_we = 1'b0;
    logic [7:0]  tb_addr = '0;
    logic [31:0] tb_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            for (int a = 0; a < 256; a++) begin
                mem[a]    <= (a >= 64) ? dv(a) : 32'h0;
                rd_cnt[a] <= 0;
            end
        end else begin
            if (tb_we) mem[tb_addr] <= tb_data;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_total <= wr_total + 1;
                end else begin
                    rd_cnt[mem_addr[7:0]] <= rd_cnt[mem_addr[7:0]] + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // expected FIFO stream
    logic [31:0] exp_w   [0:1023];
    bit          exp_eof [0:1023];
    int exp_n = 0;
    int got_n = 0;
    int frames_done = 0;

    always @(negedge clk) begin
        if (!rst && fifo_wr) begin
            if (got_n >= exp_n) begin
                chk(1'b0, "R3 unexpected FIFO word", fifo_data, 32'h0);
            end else begin
                chk(fifo_data == exp_w[got_n], "R3 FIFO word order", fifo_data, exp_w[got_n]);
                if (exp_eof[got_n]) frames_done++;
            end
            got_n++;
        end
    end

    // frame-done driver
    int  man_req = 0, man_ack = 0;
    bit  auto_en = 1'b0;
    int  auto_base = 0, auto_issued = 0;
    int  fd1 = 0, fd2 = 0, fd3 = 0;
    bit  full_en = 1'b0;

    always @(negedge clk) begin
        if (man_ack < man_req) begin
            tx_done = 1'b1;
            man_ack++;
        end else if (auto_en && (auto_issued < fd3 - auto_base)) begin
            tx_done = ($urandom % 3 == 0);
            if (tx_done) auto_issued++;
        end else begin
            tx_done = 1'b0;
        end
        fd3 = fd2; fd2 = fd1; fd1 = frames_done;
        fifo_full = full_en ? ($urandom % 4 == 0) : 1'b0;
    end

    logic [31:0] img [0:255];
    int frames_exp = 0;

    task automatic bwrite(input int a, input logic [31:0] d);
        tb_we = 1'b1; tb_addr = 8'(a); tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic add_desc(input int slot, input int len, input bit last, input int ptr);
        img[slot] = mk(len, last, ptr);
        bwrite(slot, img[slot]);
        for (int k = 0; k < len; k++) begin
            exp_w[exp_n]   = dv(ptr + k);
            exp_eof[exp_n] = last && (k == len - 1);
            exp_n++;
        end
        if (last) frames_exp++;
    endtask

    task automatic kick();
        sw_kick = 1'b1;
        @(negedge clk);
        sw_kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int rd0, wr0;
        void'($urandom(32'd2024));
        idle(4);
        rst = 1'b0;

        // R1: quiet after reset until a kick
        idle(2);
        chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'h0);
        chk(fifo_wr == 1'b0, "R1 no FIFO write after reset", 32'(fifo_wr), 32'h0);
        add_desc(0, 3, 1'b1, 64);
        add_desc(1, 2, 1'b1, 80);
        idle(10);
        chk(rd_cnt[0] == 0, "R1 no read before kick", 32'(rd_cnt[0]), 32'h0);

        // two single-descriptor frames on a two-entry ring, no frame-done yet
        kick();
        idle(60);
        chk(got_n == 5, "R3 words of two frames", 32'(got_n), 32'd5);
        chk(rd_cnt[0] == 1, "R2 descriptor 0 read once", 32'(rd_cnt[0]), 32'd1);
        chk(rd_cnt[1] == 1, "R7 in-flight descriptor not refetched", 32'(rd_cnt[1]), 32'd1);
        chk(rd_cnt[0] == 1, "R7 wrapped in-flight descriptor not refetched", 32'(rd_cnt[0]), 32'd1);
        chk(mem[0][31] == 1'b1, "R4 end descriptor held until frame-done", 32'(mem[0][31]), 32'h1);

        man_req++;
        idle(30);
        chk(mem[0] == (img[0] & 32'h7FFF_FFFF), "R5 oldest frame written back", mem[0], img[0] & 32'h7FFF_FFFF);
        chk(mem[1][31] == 1'b1, "R5 younger frame still in flight", 32'(mem[1][31]), 32'h1);
        chk(rd_cnt[0] == 2, "R6 wrap re-reads entry 0", 32'(rd_cnt[0]), 32'd2);
        chk(got_n == 5, "R8 not-ready descriptor sends nothing", 32'(got_n), 32'd5);
        rd0 = rd_cnt[0];
        idle(20);
        chk(rd_cnt[0] == rd0, "R8 parked block stays quiet", 32'(rd_cnt[0]), 32'(rd0));

        man_req++;
        idle(30);
        chk(mem[1] == (img[1] & 32'h7FFF_FFFF), "R5 second frame written back", mem[1], img[1] & 32'h7FFF_FFFF);
        wr0 = wr_total; rd0 = rd_cnt[0];
        man_req++;
        idle(30);
        chk(wr_total == wr0, "R5 spare frame-done makes no write", 32'(wr_total), 32'(wr0));
        chk(rd_cnt[0] == rd0, "R5 spare frame-done makes no read", 32'(rd_cnt[0]), 32'(rd0));

        // frame spanning two descriptors, resumed by a kick
        add_desc(0, 2, 1'b0, 96);
        add_desc(1, 1, 1'b1, 104);
        kick();
        idle(40);
        chk(got_n == 8, "R8 kick resumes at parked index", 32'(got_n), 32'd8);
        chk(mem[0] == (img[0] & 32'h7FFF_FFFF), "R4 middle descriptor written back at once", mem[0], img[0] & 32'h7FFF_FFFF);
        chk(mem[1][31] == 1'b1, "R4 end descriptor still held", 32'(mem[1][31]), 32'h1);
        man_req++;
        idle(30);
        chk(mem[1] == (img[1] & 32'h7FFF_FFFF), "R5 multi-descriptor frame retired", mem[1], img[1] & 32'h7FFF_FFFF);

        // random rounds on an eight-entry ring at another base, FIFO back-pressure
        cfg_base  = 24'd16;
        cfg_size  = 5'd8;
        full_en   = 1'b1;
        auto_base = frames_done;
        auto_en   = 1'b1;
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 8; i++) begin
                add_desc(16 + i, 1 + ($urandom % 4), (i == 7) || ($urandom % 2 == 1), 64 + i * 16 + r * 2);
            end
            kick();
            while (!(got_n == exp_n && auto_issued == frames_done - auto_base)) @(negedge clk);
            idle(40);
            for (int i = 0; i < 8; i++) begin
                chk(mem[16 + i] == (img[16 + i] & 32'h7FFF_FFFF), "R4 R5 R6 round write-back",
                    mem[16 + i], img[16 + i] & 32'h7FFF_FFFF);
            end
        end
        chk(got_n == exp_n, "R3 total words", 32'(got_n), 32'(exp_n));

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule